// File: doc/BRIEF.md
# PCI Bus Arbiter with CPU Rotation

This block decides who owns a shared PCI bus. There are six requesters: one CPU host port and five bus masters, numbered 0 to 4. Each requester raises its request line. The arbiter answers with exactly one grant at a time and leaves one idle clock between taking a grant away and giving the next one. When nobody asks for the bus, it parks the bus on the CPU.

Several static configuration inputs set the behaviour:

- the policy between the masters and the CPU (master-first or alternating);
- the event that ends the current owner's turn (request drop or cycle start);
- a hold limit in units of 32 clocks, after which a busy master is forced back into arbitration;
- a ratio that guarantees the CPU a turn after every one, two or three master grants;
- a favoured-master selection with its enable;
- whether a failed CPU posted-write retry yields the bus.

Top module: `pci_cpu_arbiter`

## Requirements
- R1: After reset, and whenever no requester is active in the idle clock between owners, `cpu_gnt` is the asserted grant. The CPU keeps a parked bus for as long as nobody else requests.
- R2: At most one of `cpu_gnt` and `mgnt[4:0]` is high in any clock. Whenever the grant moves to a different requester, at least one clock with no grant comes between the two owners.
- R3: Among the masters, bit 0 of `mreq` has the highest priority and bit 4 the lowest, when no favoured master applies.
- R4: When `cfg_fav_en` is 1, the master named by `cfg_fav_sel` wins over all other masters. The encoding is 0 for master 4, 1 for master 0, 2 for master 1 and 3 for master 2. When `cfg_fav_en` is 0, `cfg_fav_sel` has no effect.
- R5: With `cfg_cpu_every` = 0, the policy input decides. If `cfg_fair` = 0, any requesting master beats the CPU. If `cfg_fair` = 1, the CPU and the masters take turns while both sides request.
- R6: With `cfg_at_cycle_start` = 0, an owner that keeps its request high keeps its grant. Its turn ends in the clock where its request is seen low. The only other ways to end it are the hold limit (R8) and the retry yield (R10).
- R7: With `cfg_at_cycle_start` = 1, a falling edge on `cyc_active_n` while another requester waits ends the owner's turn, even if the owner still requests.
- R8: A hold-limit value N from 1 to 15 takes the grant from a master once that master has seen N×32 clocks in which `cyc_active_n` or `xfer_rdy_n` is low, and another requester waits. The grant stays high for N×32+1 clocks when the bus is busy from the first clock. N = 0 disables the limit.
- R9: A nonzero `cfg_cpu_every` value K forces a CPU grant after K consecutive master grants while the CPU requests. Each CPU grant clears the master-grant count.
- R10: When the CPU owns the bus and `cpu_wr_retry_fail` pulses, the CPU keeps the bus if `cfg_retry_yield` = 0. If `cfg_retry_yield` = 1, the bus goes back to arbitration.
- R11: The owner whose turn just ended is left out of the next decision unless it is the only requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mreq | input | 5 | Master request lines, active high |
| cpu_req | input | 1 | CPU request, active high |
| cyc_active_n | input | 1 | Bus cycle-in-progress indication, active low |
| xfer_rdy_n | input | 1 | Initiator-ready indication, active low |
| cpu_wr_retry_fail | input | 1 | One-clock pulse: CPU posted-write retry failed |
| cfg_fair | input | 1 | 0: masters before CPU, 1: alternate |
| cfg_at_cycle_start | input | 1 | 0: decide on request drop, 1: decide on cycle start |
| cfg_hold_limit | input | 4 | Master hold limit in units of 32 clocks, 0 disables |
| cfg_cpu_every | input | 2 | CPU guaranteed after this many master grants, 0 disables |
| cfg_fav_sel | input | 2 | Favoured master select |
| cfg_fav_en | input | 1 | Enables the favoured master |
| cfg_retry_yield | input | 1 | Yield bus after failed CPU retry |
| mgnt | output | 5 | Master grants, one-hot or zero |
| cpu_gnt | output | 1 | CPU grant |

## Verification
On every clock, assertions check the following:

- the grants are one-hot;
- an idle clock separates two different owners;
- the bus parks on the CPU when the request lines are empty;
- the CPU wins once the rotation quota is reached;
- a master past its hold limit loses the bus;
- in request-drop mode, an owner that keeps requesting keeps its grant.

Other properties can only be shown by the bench scenarios:

- the priority order and favoured-master mapping, swept over every subset of masters;
- the exact length of the hold window for each limit value;
- the run lengths of master grants between CPU grants in each policy;
- the cycle-start and retry-yield behaviour.

// File: rtl/pci_cpu_arbiter.sv
module pci_cpu_arbiter #(
  parameter int TO_UNIT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] mreq,
  input  logic       cpu_req,
  input  logic       cyc_active_n,
  input  logic       xfer_rdy_n,
  input  logic       cpu_wr_retry_fail,
  input  logic       cfg_fair,
  input  logic       cfg_at_cycle_start,
  input  logic [3:0] cfg_hold_limit,
  input  logic [1:0] cfg_cpu_every,
  input  logic [1:0] cfg_fav_sel,
  input  logic       cfg_fav_en,
  input  logic       cfg_retry_yield,
  output logic [4:0] mgnt,
  output logic       cpu_gnt
);
  localparam int NM = 5;
  localparam logic [2:0] CPU = 3'd5;
  localparam int TW = $clog2(15 * TO_UNIT + 1);

  logic          granted, last_m, cyc_q;
  logic [2:0]    owner, next_owner, lo_pick, fav_idx, m_pick;
  logic [1:0]    rot_cnt;
  logic [TW-1:0] tcnt, limit;
  logic [5:0]    req6, others, cand;
  logic          own_req, any_other, owner_cpu, busy, expire, cyc_fall, release_now, pick_cpu;

  assign req6        = {cpu_req, mreq};
  assign owner_cpu   = (owner == CPU);
  assign own_req     = req6[owner];
  assign others      = req6 & ~(6'b1 << owner);
  assign any_other   = |others;
  assign busy        = !cyc_active_n || !xfer_rdy_n;
  assign cyc_fall    = cyc_q && !cyc_active_n;
  assign limit       = TW'(cfg_hold_limit) * TW'(TO_UNIT);
  assign expire      = (cfg_hold_limit != 4'd0) && !owner_cpu && (tcnt >= limit);

  assign release_now = granted && (
      (!own_req && (any_other || !owner_cpu)) ||
      (any_other && ((cfg_at_cycle_start && cyc_fall) || expire ||
                     (owner_cpu && cfg_retry_yield && cpu_wr_retry_fail))));

  assign cand = any_other ? others : req6;

  always_comb begin
    lo_pick = 3'd0;
    for (int i = NM - 1; i >= 0; i--)
      if (cand[i]) lo_pick = 3'(i);
  end

  always_comb begin
    case (cfg_fav_sel)
      2'd0:    fav_idx = 3'd4;
      2'd1:    fav_idx = 3'd0;
      2'd2:    fav_idx = 3'd1;
      default: fav_idx = 3'd2;
    endcase
  end

  assign m_pick = (cfg_fav_en && cand[fav_idx]) ? fav_idx : lo_pick;

  always_comb begin
    if (cand[4:0] == 5'd0)        pick_cpu = 1'b1;
    else if (!cand[5])            pick_cpu = 1'b0;
    else if (cfg_cpu_every != 0)  pick_cpu = (rot_cnt >= cfg_cpu_every);
    else if (cfg_fair)            pick_cpu = last_m;
    else                          pick_cpu = 1'b0;
  end

  assign next_owner = pick_cpu ? CPU : m_pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      granted <= 1'b1;
      owner   <= CPU;
      last_m  <= 1'b0;
      rot_cnt <= 2'd0;
      tcnt    <= '0;
      cyc_q   <= 1'b1;
    end else begin
      cyc_q <= cyc_active_n;
      if (granted) begin
        if (release_now) granted <= 1'b0;
        if (busy && !owner_cpu && tcnt < limit) tcnt <= tcnt + 1'b1;
      end else begin
        granted <= 1'b1;
        owner   <= next_owner;
        tcnt    <= '0;
        if (pick_cpu) begin
          rot_cnt <= 2'd0;
          last_m  <= 1'b0;
        end else begin
          rot_cnt <= (rot_cnt == 2'd3) ? 2'd3 : rot_cnt + 2'd1;
          last_m  <= 1'b1;
        end
      end
    end
  end

  assign cpu_gnt = granted && owner_cpu;
  assign mgnt    = (granted && !owner_cpu) ? (5'b1 << owner) : 5'b0;

  logic [5:0] gv;
  assign gv = {cpu_gnt, mgnt};

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gv));

  a_r2_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (gv != 6'd0 && $past(gv) != 6'd0) |-> gv == $past(gv));

  a_r1_park: assert property (@(posedge clk) disable iff (!rst_n)
    (gv == 6'd0 && mreq == 5'd0 && !cpu_req) |=> cpu_gnt);

  a_r9_cpu_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (gv == 6'd0 && cfg_cpu_every != 2'd0 && rot_cnt >= cfg_cpu_every && cpu_req && mreq != 5'd0)
      |=> cpu_gnt);

  a_r8_hold_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (mgnt != 5'd0 && cfg_hold_limit != 4'd0 && tcnt >= limit && any_other) |=> gv == 6'd0);

  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (gv != 6'd0 && !cfg_at_cycle_start && own_req && !expire &&
     !(owner_cpu && cfg_retry_yield && cpu_wr_retry_fail)) |=> $stable(gv));
endmodule

// File: tb/tb_pci_cpu_arbiter.sv
module tb_pci_cpu_arbiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] mreq = '0;
  logic cpu_req = 0, cyc_active_n = 1, xfer_rdy_n = 1, cpu_wr_retry_fail = 0;
  logic cfg_fair = 0, cfg_at_cycle_start = 0, cfg_fav_en = 0, cfg_retry_yield = 0;
  logic [3:0] cfg_hold_limit = 0;
  logic [1:0] cfg_cpu_every = 0, cfg_fav_sel = 0;
  logic [4:0] mgnt;
  logic cpu_gnt;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pci_cpu_arbiter dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int who();
    if (cpu_gnt) return 5;
    for (int i = 0; i < 5; i++) if (mgnt[i]) return i;
    return -1;
  endfunction

  task automatic settle_park();
    mreq = '0; cpu_req = 0; cyc_active_n = 1; xfer_rdy_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rotation_run(input bit fair, input int k);
    int seq[13];
    int run, ncpu;
    bit seen;
    cfg_fair = fair; cfg_cpu_every = 2'(k);
    settle_park();
    cpu_req = 1; mreq = 5'b11111;
    @(negedge clk);
    seq[0] = who();
    for (int n = 1; n < 13; n++) begin
      int cur, lim;
      cur = who();
      repeat (2) @(negedge clk);
      if (cur == 5) cpu_req = 0; else mreq[cur] = 0;
      @(negedge clk);
      if (cur == 5) cpu_req = 1; else mreq[cur] = 1;
      lim = 0;
      while (who() < 0 && lim < 20) begin @(negedge clk); lim++; end
      seq[n] = who();
    end
    run = 0; ncpu = 0; seen = (seq[0] == 5);
    for (int n = 1; n < 13; n++) begin
      if (seq[n] == 5) begin
        ncpu++;
        if (seen && k != 0) check("R9 master run before CPU", run, k);
        if (seen && k == 0 && fair) check("R5 fair run length", run, 1);
        seen = 1; run = 0;
      end else begin
        run++;
        if (seq[n-1] != 5) check("R11 previous owner skipped", int'(seq[n] != seq[n-1]), 1);
      end
    end
    if (k == 0 && !fair) check("R5 CPU starved by masters", ncpu, 0);
    else check("R9/R5 CPU got turns", int'(ncpu >= 3), 1);
    settle_park();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset cpu_gnt", int'(cpu_gnt), 1);
    check("R1 reset mgnt", int'(mgnt), 0);

    // R3, R4: all subsets, favoured on/off, every select
    for (int en = 0; en < 2; en++)
      for (int sel = 0; sel < 4; sel++)
        for (int s = 1; s < 32; s++) begin
          int fav, exp;
          cfg_fav_en = en[0]; cfg_fav_sel = 2'(sel);
          fav = (sel == 0) ? 4 : sel - 1;
          exp = 0;
          for (int i = 4; i >= 0; i--) if (s[i]) exp = i;
          if (en != 0 && s[fav]) exp = fav;
          mreq = 5'(s);
          @(negedge clk);
          check("R2 idle clock before grant", int'({cpu_gnt, mgnt}), 0);
          @(negedge clk);
          check(en != 0 ? "R4 favoured master" : "R3 fixed order", int'(mgnt), 1 << exp);
          mreq = '0;
          repeat (2) @(negedge clk);
          check("R1 park after release", int'(cpu_gnt), 1);
        end
    cfg_fav_en = 0;

    rotation_run(0, 0);
    rotation_run(1, 0);
    rotation_run(0, 1);
    rotation_run(0, 2);
    rotation_run(0, 3);
    rotation_run(1, 2);
    cfg_fair = 0; cfg_cpu_every = 0;

    // R8: hold limit sweep
    for (int n = 0; n < 16; n++) begin
      int cnt;
      cfg_hold_limit = 4'(n);
      settle_park();
      mreq = 5'b00011; cyc_active_n = 0; xfer_rdy_n = 0;
      repeat (2) @(negedge clk);
      cnt = 0;
      while (mgnt[0] && cnt < 800) begin cnt++; @(negedge clk); end
      if (n == 0) check("R8 limit 0 never expires", cnt, 800);
      else begin
        check("R8 hold window", cnt, n * 32 + 1);
        @(negedge clk);
        check("R8 waiting master granted", int'(mgnt), 2);
      end
    end
    cfg_hold_limit = 0;

    // R7: cycle-start mode
    cfg_at_cycle_start = 1;
    settle_park();
    mreq = 5'b00101;
    repeat (5) @(negedge clk);
    check("R7 no edge keeps owner", int'(mgnt), 1);
    cyc_active_n = 0;
    repeat (2) @(negedge clk);
    check("R7 cycle start moves grant", int'(mgnt), 4);

    // R6: same edge ignored in request-drop mode
    cfg_at_cycle_start = 0;
    settle_park();
    mreq = 5'b00101;
    repeat (3) @(negedge clk);
    cyc_active_n = 0;
    repeat (5) @(negedge clk);
    check("R6 held request keeps grant", int'(mgnt), 1);
    mreq[0] = 0;
    repeat (2) @(negedge clk);
    check("R6 request drop hands over", int'(mgnt), 4);

    // R10: retry yield
    settle_park();
    cpu_req = 1; mreq = 5'b01000;
    repeat (3) @(negedge clk);
    check("R6 CPU holding keeps bus", int'(cpu_gnt), 1);
    cfg_retry_yield = 0; cpu_wr_retry_fail = 1;
    @(negedge clk); cpu_wr_retry_fail = 0;
    repeat (3) @(negedge clk);
    check("R10 no yield keeps CPU", int'(cpu_gnt), 1);
    cfg_retry_yield = 1; cpu_wr_retry_fail = 1;
    @(negedge clk); cpu_wr_retry_fail = 0;
    @(negedge clk);
    check("R10 yield grants master", int'(mgnt), 8);
    settle_park();
    check("R1 final park", int'(cpu_gnt), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule